// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when a DDR SDRAM controller must spend a command slot on refresh. A free-running interval counter, clocked by the controller clock, adds one owed refresh every refresh interval. The default interval is 7.8 us, which is 8192 refreshes in 64 ms. The number of owed refreshes is the backlog, and it never exceeds a hard ceiling of eight. While the backlog is non-zero the block asks the command arbiter for a refresh slot. When the backlog reaches the ceiling the request is also marked urgent, and the arbiter must then let it win. The arbiter grants a refresh only after it has closed every bank. The block trusts the grant only when the arbiter also reports that all banks are idle.

Every time a refresh is issued, the block holds off all commands other than NOP for the refresh row cycle time. It also manages self-refresh. On request it asks for a slot to issue the refresh encoding with clock enable dropping. It keeps clock enable low until the request is withdrawn. After exit it keeps non-read commands back for the longer exit delay, and reads back for the fixed exit-to-read count. All nanosecond limits become cycle counts by rounding up against a clock-period parameter given in picoseconds. The refresh interval is the one exception: it rounds down, so refresh never falls behind. With a 4.3 ns clock the counts are 1813, 17, 18 and 200.

The sequencer has five states. NORMAL is the running state and the state after reset. RECOVERY is the window after an issued refresh. SR_ENTRY waits for a grant to enter self-refresh. SR_ACTIVE holds clock enable low. SR_EXIT is the post-exit wait. The transitions are:
- NORMAL to RECOVERY on an accepted refresh grant.
- NORMAL to SR_ENTRY on a self-refresh request.
- RECOVERY to NORMAL when the recovery count ends.
- SR_ENTRY to SR_ACTIVE on an accepted grant.
- SR_ENTRY to NORMAL when the request is withdrawn before a grant.
- SR_ACTIVE to SR_EXIT when the request drops.
- SR_EXIT to NORMAL when the read wait ends.

Top module: `rfsh_sched`

## Requirements
- R1: After reset the backlog is 0. It rises by one after every REFI_CYC clock cycles in which the sequencer is not in SR_ACTIVE, where REFI_CYC is 1813 by default. It saturates at MAX_OWED, which is 8, and `owed_cnt` reports it.
- R2: `ref_req` is 1 exactly when the sequencer is in NORMAL and the backlog is non-zero.
- R3: `ref_urgent` is 1 exactly when the sequencer is in NORMAL and the backlog equals MAX_OWED.
- R4: A grant is accepted only when `ref_gnt`=1 and `banks_idle`=1 in the same cycle. An accepted grant while `ref_req`=1 lowers the backlog by one and enters RECOVERY. A grant with `banks_idle`=0, or with no request showing, changes neither the backlog nor `cmd_hold`.
- R5: After an accepted refresh grant, `cmd_hold` is 1 and `ref_req` is 0 for exactly RFC_CYC cycles, starting the next cycle. RFC_CYC is 17 by default. `cmd_hold` then returns to 0.
- R6: In NORMAL with `sr_req`=1 and no accepted refresh grant, `sre_req` is 1 from the next cycle and `ref_req` is 0. A refresh grant in the same cycle takes priority. Dropping `sr_req` before a grant returns the sequencer to NORMAL.
- R7: An accepted grant while `sre_req`=1 drives `cke` to 0 from the next cycle. The same grant clears the backlog and the interval counter. The backlog stays 0 for as long as `cke` is 0.
- R8: When `sr_req` is 0 in SR_ACTIVE, `cke` returns to 1 the next cycle. `cmd_hold` then stays 1 for exactly XSNR_CYC cycles counted from that cycle. XSNR_CYC is 18 by default.
- R9: From self-refresh exit, `rd_hold` stays 1 for exactly XSRD_CYC cycles, which is 200 by default. The sequencer then returns to NORMAL, and the interval counter runs throughout this wait.
- R10: While reset is held, and right after it, `cke` is 1. Every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant for the pending refresh or self-refresh entry |
| banks_idle | input | 1 | All banks are precharged this cycle |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_req | output | 1 | Refresh owed, asking for a command slot |
| ref_urgent | output | 1 | Backlog at the ceiling, request must win |
| sre_req | output | 1 | Asking for a slot to issue self-refresh entry |
| cke | output | 1 | Clock enable to the memory |
| cmd_hold | output | 1 | Only NOP may be issued |
| rd_hold | output | 1 | No read may be issued |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of owed refreshes |

## Verification
A long directed run with no grants is used first. It measures the first request at exactly one interval, and it separates the backlog ceiling from a plain counter, because urgency must appear at eight and stay there. Next come single grants, once with the banks busy and once idle. These tell an accepted grant apart from an ignored one, and the length of the recovery window is measured exactly. A self-refresh cycle then covers entry, an aborted entry, a hold longer than an interval that shows the counter is frozen, and the two different exit waits. Random phases with mixed grant rates, random bank-idle states and rare self-refresh toggles follow. Every cycle of these phases is compared against a bench model. This catches races between interval ticks, grants and state changes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_RECOVERY,
        ST_SR_ENTRY,
        ST_SR_ACTIVE,
        ST_SR_EXIT
    } rfsh_state_e;

    // Round a time up to whole clock cycles.
    function automatic int cycles_ceil(input int time_ps, input int clk_ps);
        return (time_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int PERIOD_CYC = 1813
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CW = $clog2(PERIOD_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(PERIOD_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int MAX_OWED = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            inc,
    input  logic                            dec,
    input  logic                            clr,
    output logic [$clog2(MAX_OWED+1)-1:0]   owed,
    output logic                            full,
    output logic                            nonzero
);
    localparam int OW = $clog2(MAX_OWED + 1);

    assign full    = (owed == OW'(MAX_OWED));
    assign nonzero = (owed != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (!full) owed <= owed + 1'b1;
                2'b01:   if (nonzero) owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int RFC_CYC  = 17,
    parameter int XSNR_CYC = 18,
    parameter int XSRD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_ok,
    input  logic sr_req,
    input  logic owed_nz,
    input  logic owed_full,
    output logic ref_req,
    output logic ref_urgent,
    output logic sre_req,
    output logic cke,
    output logic cmd_hold,
    output logic rd_hold,
    output logic owed_dec,
    output logic sr_clear,
    output logic timer_run
);
    localparam int WAIT_MAX = max3(RFC_CYC, XSNR_CYC, XSRD_CYC);
    localparam int CW       = $clog2(WAIT_MAX + 1);

    rfsh_state_e   st_q, st_d;
    logic [CW-1:0] wait_q;

    // State register and shared wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_NORMAL;
            wait_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                wait_q <= '0;
            else if (st_q == ST_RECOVERY || st_q == ST_SR_EXIT)
                wait_q <= wait_q + 1'b1;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_NORMAL: begin
                if (gnt_ok && owed_nz)  st_d = ST_RECOVERY;
                else if (sr_req)        st_d = ST_SR_ENTRY;
            end
            ST_RECOVERY: begin
                if (wait_q == CW'(RFC_CYC - 1)) st_d = ST_NORMAL;
            end
            ST_SR_ENTRY: begin
                if (gnt_ok)             st_d = ST_SR_ACTIVE;
                else if (!sr_req)       st_d = ST_NORMAL;
            end
            ST_SR_ACTIVE: begin
                if (!sr_req)            st_d = ST_SR_EXIT;
            end
            ST_SR_EXIT: begin
                if (wait_q == CW'(XSRD_CYC - 1)) st_d = ST_NORMAL;
            end
            default: st_d = ST_NORMAL;
        endcase
    end

    // Outputs
    always_comb begin
        ref_req    = (st_q == ST_NORMAL) && owed_nz;
        ref_urgent = (st_q == ST_NORMAL) && owed_full;
        sre_req    = (st_q == ST_SR_ENTRY);
        cke        = (st_q != ST_SR_ACTIVE);
        cmd_hold   = (st_q == ST_RECOVERY) || (st_q == ST_SR_ACTIVE) ||
                     ((st_q == ST_SR_EXIT) && (wait_q < CW'(XSNR_CYC)));
        rd_hold    = cmd_hold || (st_q == ST_SR_EXIT);
        owed_dec   = (st_q == ST_NORMAL) && gnt_ok && owed_nz;
        sr_clear   = (st_q == ST_SR_ENTRY) && gnt_ok;
        timer_run  = (st_q != ST_SR_ACTIVE);
    end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int CLK_PS   = 4300,
    parameter int REFI_PS  = 7800000,
    parameter int RFC_PS   = 70000,
    parameter int XSNR_PS  = 75000,
    parameter int XSRD_CYC = 200,
    parameter int MAX_OWED = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ref_gnt,
    input  logic                          banks_idle,
    input  logic                          sr_req,
    output logic                          ref_req,
    output logic                          ref_urgent,
    output logic                          sre_req,
    output logic                          cke,
    output logic                          cmd_hold,
    output logic                          rd_hold,
    output logic [$clog2(MAX_OWED+1)-1:0] owed_cnt
);
    // Interval rounds down so refresh never lags; waits round up.
    localparam int REFI_CYC = REFI_PS / CLK_PS;
    localparam int RFC_CYC  = cycles_ceil(RFC_PS, CLK_PS);
    localparam int XSNR_CYC = cycles_ceil(XSNR_PS, CLK_PS);

    logic gnt_ok, tick, owed_dec, sr_clear, timer_run, owed_full, owed_nz;

    assign gnt_ok = ref_gnt && banks_idle;

    rfsh_interval_timer #(.PERIOD_CYC(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .clear (sr_clear),
        .tick  (tick)
    );

    rfsh_backlog #(.MAX_OWED(MAX_OWED)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (owed_dec),
        .clr     (sr_clear),
        .owed    (owed_cnt),
        .full    (owed_full),
        .nonzero (owed_nz)
    );

    rfsh_seq #(
        .RFC_CYC  (RFC_CYC),
        .XSNR_CYC (XSNR_CYC),
        .XSRD_CYC (XSRD_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_ok     (gnt_ok),
        .sr_req     (sr_req),
        .owed_nz    (owed_nz),
        .owed_full  (owed_full),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .sre_req    (sre_req),
        .cke        (cke),
        .cmd_hold   (cmd_hold),
        .rd_hold    (rd_hold),
        .owed_dec   (owed_dec),
        .sr_clear   (sr_clear),
        .timer_run  (timer_run)
    );
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int MAX_OWED = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ref_gnt,
    input logic                          banks_idle,
    input logic                          sr_req,
    input logic                          ref_req,
    input logic                          ref_urgent,
    input logic                          sre_req,
    input logic                          cke,
    input logic                          cmd_hold,
    input logic                          rd_hold,
    input logic [$clog2(MAX_OWED+1)-1:0] owed_cnt
);
    a_r1_owed_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        int'(owed_cnt) <= MAX_OWED);

    a_r1_owed_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(owed_cnt) |-> (int'(owed_cnt) == int'($past(owed_cnt)) + 1 ||
                                int'(owed_cnt) == int'($past(owed_cnt)) - 1 ||
                                owed_cnt == '0));

    a_r2_req_needs_backlog: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> owed_cnt != '0);

    a_r3_urgent_at_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req && int'(owed_cnt) == MAX_OWED));

    a_r4_grant_starts_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt && banks_idle) |=> (cmd_hold && !ref_req && cke));

    a_r4_busy_grant_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt && !banks_idle) |=> !cmd_hold);

    a_r6_one_request_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_req && sre_req));

    a_r7_entry_clears_backlog: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> owed_cnt == '0);

    a_r7_quiet_in_self_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd_hold && !ref_req && !sre_req && owed_cnt == '0));

    a_r8_exit_holds_commands: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd_hold && rd_hold));

    a_r9_read_hold_covers_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hold |-> rd_hold);
endmodule

bind rfsh_sched rfsh_sched_chk #(.MAX_OWED(MAX_OWED)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .banks_idle (banks_idle),
    .sr_req     (sr_req),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .sre_req    (sre_req),
    .cke        (cke),
    .cmd_hold   (cmd_hold),
    .rd_hold    (rd_hold),
    .owed_cnt   (owed_cnt)
);

// File: tb/rfsh_sched_bench.sv
`timescale 1ns/1ps
module rfsh_sched_bench;
    localparam int B_CLK_PS = 4300;
    localparam int B_REFI   = 7800000 / B_CLK_PS;                 // 1813
    localparam int B_RFC    = (70000 + B_CLK_PS - 1) / B_CLK_PS;  // 17
    localparam int B_XSNR   = (75000 + B_CLK_PS - 1) / B_CLK_PS;  // 18
    localparam int B_XSRD   = 200;
    localparam int B_MAX    = 8;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0, banks_idle = 1'b0, sr_req = 1'b0;
    logic ref_req, ref_urgent, sre_req, cke, cmd_hold, rd_hold;
    logic [3:0] owed_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rfsh_sched u_rfsh_sched (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .banks_idle(banks_idle),
        .sr_req(sr_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .sre_req(sre_req), .cke(cke), .cmd_hold(cmd_hold), .rd_hold(rd_hold),
        .owed_cnt(owed_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural expectation: 0 normal, 1 recovery, 2 entry, 3 active, 4 exit
    int m_st = 0, m_t = 0, m_owed = 0, m_w = 0;

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_owed = 0; m_w = 0;
        end else begin
            bit acc, tick, dec, clr;
            int nst;
            acc  = ref_gnt && banks_idle;
            tick = (m_st != 3) && (m_t == B_REFI - 1);
            dec  = 1'b0;
            clr  = 1'b0;
            nst  = m_st;
            case (m_st)
                0: if (acc && m_owed > 0) begin nst = 1; dec = 1'b1; end
                   else if (sr_req) nst = 2;
                1: if (m_w == B_RFC - 1) nst = 0;
                2: if (acc) begin nst = 3; clr = 1'b1; end
                   else if (!sr_req) nst = 0;
                3: if (!sr_req) nst = 4;
                default: if (m_w == B_XSRD - 1) nst = 0;
            endcase
            if (clr) m_t = 0;
            else if (m_st != 3) m_t = tick ? 0 : m_t + 1;
            if (clr) m_owed = 0;
            else m_owed = min_int(m_owed + (tick ? 1 : 0) - (dec ? 1 : 0), B_MAX);
            if (nst != m_st) m_w = 0;
            else if (m_st == 1 || m_st == 4) m_w = m_w + 1;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            bit e_hold;
            e_hold = (m_st == 1) || (m_st == 3) || (m_st == 4 && m_w < B_XSNR);
            chk(int'(owed_cnt) == m_owed, "R1 owed_cnt", owed_cnt, m_owed);
            chk(ref_req == (m_st == 0 && m_owed > 0), "R2 ref_req", ref_req, m_st == 0 && m_owed > 0);
            chk(ref_urgent == (m_st == 0 && m_owed == B_MAX), "R3 ref_urgent", ref_urgent, m_st == 0 && m_owed == B_MAX);
            chk(sre_req == (m_st == 2), "R6 sre_req", sre_req, m_st == 2);
            chk(cke == (m_st != 3), "R7 cke", cke, m_st != 3);
            chk(cmd_hold == e_hold, "R5/R8 cmd_hold", cmd_hold, e_hold);
            chk(rd_hold == (e_hold || m_st == 4), "R9 rd_hold", rd_hold, e_hold || m_st == 4);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            finish_run();
        end
    end

    initial begin
        int n, seed;
        seed = $urandom(32'd20031);
        step(4);
        // R10: reset values
        chk(cke == 1'b1 && !ref_req && !ref_urgent && !sre_req && !cmd_hold && !rd_hold && owed_cnt == 0,
            "R10 reset outputs", {cke, ref_req, ref_urgent, sre_req, cmd_hold, rd_hold}, 6'b100000);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1: first owed refresh after exactly one interval
        n = 0;
        do begin step(1); n++; end while (!ref_req && n < 3 * B_REFI);
        chk(n == B_REFI, "R1 first interval", n, B_REFI);

        // R3: backlog reaches the ceiling and stays there
        step(7 * B_REFI);
        chk(ref_urgent && owed_cnt == B_MAX, "R3 urgent at ceiling", owed_cnt, B_MAX);
        step(B_REFI + 5);
        chk(owed_cnt == B_MAX, "R1 saturation", owed_cnt, B_MAX);

        // R4: grant with banks busy is ignored
        ref_gnt = 1'b1; banks_idle = 1'b0; step(1);
        ref_gnt = 1'b0; step(1);
        chk(owed_cnt == B_MAX && !cmd_hold, "R4 busy banks grant ignored", owed_cnt, B_MAX);

        // R4/R5: accepted grant and recovery length
        ref_gnt = 1'b1; banks_idle = 1'b1; step(1);
        ref_gnt = 1'b0;
        chk(owed_cnt == B_MAX - 1, "R4 grant decrements", owed_cnt, B_MAX - 1);
        n = 0;
        while (cmd_hold && n < 1000) begin
            chk(!ref_req, "R5 no request in recovery", ref_req, 0);
            step(1); n++;
        end
        chk(n == B_RFC, "R5 recovery length", n, B_RFC);

        // R6: aborted entry
        sr_req = 1'b1; step(1);
        chk(sre_req && !ref_req, "R6 entry request", sre_req, 1);
        sr_req = 1'b0; step(1);
        chk(!sre_req && ref_req, "R6 abort returns", ref_req, 1);

        // R7: self-refresh entry
        sr_req = 1'b1; step(3);
        ref_gnt = 1'b1; step(1);
        ref_gnt = 1'b0;
        chk(!cke && owed_cnt == 0, "R7 entry clears backlog", owed_cnt, 0);
        step(2 * B_REFI);
        chk(!cke && owed_cnt == 0, "R7 frozen in self-refresh", owed_cnt, 0);

        // R8/R9: exit waits
        sr_req = 1'b0; step(1);
        chk(cke == 1'b1, "R8 cke returns", cke, 1);
        n = 0;
        while (cmd_hold && n < 1000) begin step(1); n++; end
        chk(n == B_XSNR, "R8 non-read wait", n, B_XSNR);
        while (rd_hold && n < 1000) begin step(1); n++; end
        chk(n == B_XSRD, "R9 read wait", n, B_XSRD);

        // Random phases with varying grant rates
        for (int ph = 0; ph < 8; ph++) begin
            int rate;
            rate = (ph % 2 == 0) ? 3 : 400;
            for (int c = 0; c < 5000; c++) begin
                if ($urandom_range(0, 1499) == 0) sr_req = !sr_req;
                ref_gnt = ((ref_req || sre_req) && $urandom_range(0, rate) == 0) ||
                          ($urandom_range(0, 299) == 0);
                banks_idle = ($urandom_range(0, 9) != 0);
                step(1);
            end
        end
        ref_gnt = 1'b0; sr_req = 1'b0;
        step(2);
        done = 1'b1;
        finish_run();
    end
endmodule